// File: doc/BRIEF.md
# Dual-Mode Packet Byte Counter

This block measures the length of each packet that a repeater sends on, in bytes. While a packet is active, every byte strobe adds one to the count. A start-of-frame delimiter (SFD) pulse changes what is being measured. After the pulse, the count restarts from zero and runs over the full 16-bit width, so it measures only the payload that follows the delimiter. If no delimiter arrives, the count covers the whole burst from the first preamble byte. It is then capped at a narrower width, and a size-select input picks that width: 7 bits (cap 127) or 11 bits (cap 2047).

A status bit reports which of the two modes produced the final value. It is set when the packet ends if no delimiter pulse came during the packet. A collision flag is also captured during the packet. The block does not interpret this flag; it is held beside the count so that software can judge whether a missing delimiter is real. Count and status stay frozen between packets and reset when the next packet begins.

Top module: `pkt_byte_counter`

## Requirements
- R1: After reset, `count_o` is 0, `no_sfd_o` is 0 and `col_o` is 0.
- R2: On the first cycle with `pkt_active_i` high after a cycle with it low, the count is cleared to 0 (or set to 1 if `byte_stb_i` is also high and `sfd_pulse_i` is low). In the same cycle `no_sfd_o` and `col_o` are cleared, except that `col_o` is set if `col_i` is high in that cycle.
- R3: In any later active cycle without an SFD pulse, a high `byte_stb_i` adds exactly 1 to the count, unless the count is at its cap. The new value shows after the next rising clock edge.
- R4: An active cycle with `sfd_pulse_i` high sets the count to 0. A byte strobe in that same cycle is not counted. For the rest of the packet the cap is 65535, and the count holds there instead of wrapping.
- R5: Until an SFD pulse occurs in the packet, and with `big_size_i` = 0, the count saturates at 127.
- R6: Until an SFD pulse occurs in the packet, and with `big_size_i` = 1, the count saturates at 2047.
- R7: `no_sfd_o` is 0 after every clock edge at which `pkt_active_i` was high. At the edge where `pkt_active_i` is first low, `no_sfd_o` becomes 1 if no SFD pulse came during the packet, and 0 otherwise.
- R8: While `pkt_active_i` is low, `byte_stb_i`, `sfd_pulse_i` and `col_i` have no effect. `count_o`, `no_sfd_o` and `col_o` hold their values (apart from the single update in R7).
- R9: `col_o` becomes 1 after any active cycle with `col_i` high. It stays at 1 until the next packet start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pkt_active_i | input | 1 | High while a packet is being repeated |
| byte_stb_i | input | 1 | One byte passed in this cycle |
| sfd_pulse_i | input | 1 | Start-of-frame delimiter detected in this cycle |
| big_size_i | input | 1 | No-delimiter cap select: 0 gives 127, 1 gives 2047 |
| col_i | input | 1 | Collision seen in this cycle |
| count_o | output | 16 | Byte count of the current or last packet |
| no_sfd_o | output | 1 | Last packet was counted without a delimiter |
| col_o | output | 1 | A collision occurred in the current or last packet |

## Verification
Every output is a register, so each input cycle's effect shows exactly one rising edge later. This includes the status bit, which updates at the edge where the packet-active input is first sampled low. The bench drives inputs on the falling edge and advances a reference model on those inputs. It then waits one rising edge and compares all three outputs on the next falling edge, so each comparison checks the result due from the cycle just driven. The explicit end-of-packet checks read the outputs one edge after the last idle cycle. By that point both the frozen count and the status update are due.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

  typedef enum logic [1:0] {
    MODE_SHORT = 2'd0,
    MODE_LONG  = 2'd1,
    MODE_FULL  = 2'd2
  } count_mode_e;

  function automatic count_mode_e pick_mode(input logic sfd_seen, input logic big_size);
    if (sfd_seen)      return MODE_FULL;
    else if (big_size) return MODE_LONG;
    else               return MODE_SHORT;
  endfunction

endpackage

// File: rtl/pbc_frame_edges.sv
module pbc_frame_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  output logic start_o,
  output logic end_o
);

  logic active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= active_i;
  end

  assign start_o = active_i & ~active_q;
  assign end_o   = ~active_i & active_q;

endmodule

// File: rtl/pbc_mode_track.sv
module pbc_mode_track
  import pbc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        active_i,
  input  logic        start_i,
  input  logic        end_i,
  input  logic        sfd_i,
  input  logic        big_i,
  input  logic        col_i,
  output count_mode_e mode_o,
  output logic        sfd_seen_o,
  output logic        no_sfd_o,
  output logic        col_o
);

  logic sfd_seen_q, no_sfd_q, col_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sfd_seen_q <= 1'b0;
      no_sfd_q   <= 1'b0;
      col_q      <= 1'b0;
    end else if (active_i) begin
      no_sfd_q <= 1'b0;
      if (sfd_i)        sfd_seen_q <= 1'b1;
      else if (start_i) sfd_seen_q <= 1'b0;
      col_q <= start_i ? col_i : (col_q | col_i);
    end else if (end_i) begin
      no_sfd_q <= ~sfd_seen_q;
    end
  end

  assign mode_o     = pick_mode(sfd_seen_q, big_i);
  assign sfd_seen_o = sfd_seen_q;
  assign no_sfd_o   = no_sfd_q;
  assign col_o      = col_q;

endmodule

// File: rtl/pbc_sat_counter.sv
module pbc_sat_counter
  import pbc_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int SHORT_W = 7,
  parameter int LONG_W  = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic             start_i,
  input  logic             sfd_i,
  input  logic             stb_i,
  input  count_mode_e      mode_i,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] SHORT_MAX = CNT_W'((1 << SHORT_W) - 1);
  localparam logic [CNT_W-1:0] LONG_MAX  = CNT_W'((1 << LONG_W) - 1);
  localparam logic [CNT_W-1:0] FULL_MAX  = '1;

  function automatic logic [CNT_W-1:0] cap_of(input count_mode_e m);
    case (m)
      MODE_SHORT: return SHORT_MAX;
      MODE_LONG:  return LONG_MAX;
      default:    return FULL_MAX;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] sat_step(input logic [CNT_W-1:0] v,
                                                input logic [CNT_W-1:0] cap);
    return (v >= cap) ? v : v + 1'b1;
  endfunction

  logic [CNT_W-1:0] cnt_q, cnt_d, cap_w;

  assign cap_w = cap_of(mode_i);

  always_comb begin
    cnt_d = cnt_q;
    if (active_i) begin
      if (sfd_i)        cnt_d = '0;
      else if (start_i) cnt_d = {{(CNT_W-1){1'b0}}, stb_i};
      else if (stb_i)   cnt_d = sat_step(cnt_q, cap_w);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/pkt_byte_counter.sv
module pkt_byte_counter
  import pbc_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int SHORT_W = 7,
  parameter int LONG_W  = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_active_i,
  input  logic             byte_stb_i,
  input  logic             sfd_pulse_i,
  input  logic             big_size_i,
  input  logic             col_i,
  output logic [CNT_W-1:0] count_o,
  output logic             no_sfd_o,
  output logic             col_o
);

  logic        start_w, end_w, sfd_seen_w;
  count_mode_e mode_w;

  pbc_frame_edges u_edges (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (pkt_active_i),
    .start_o  (start_w),
    .end_o    (end_w)
  );

  pbc_mode_track u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .active_i   (pkt_active_i),
    .start_i    (start_w),
    .end_i      (end_w),
    .sfd_i      (sfd_pulse_i),
    .big_i      (big_size_i),
    .col_i      (col_i),
    .mode_o     (mode_w),
    .sfd_seen_o (sfd_seen_w),
    .no_sfd_o   (no_sfd_o),
    .col_o      (col_o)
  );

  pbc_sat_counter #(
    .CNT_W   (CNT_W),
    .SHORT_W (SHORT_W),
    .LONG_W  (LONG_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (pkt_active_i),
    .start_i  (start_w),
    .sfd_i    (sfd_pulse_i),
    .stb_i    (byte_stb_i),
    .mode_i   (mode_w),
    .count_o  (count_o)
  );

endmodule

// File: rtl/pbc_checker.sv
module pbc_checker #(
  parameter int CNT_W   = 16,
  parameter int SHORT_W = 7,
  parameter int LONG_W  = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pkt_active_i,
  input logic             byte_stb_i,
  input logic             sfd_pulse_i,
  input logic             big_size_i,
  input logic             col_i,
  input logic [CNT_W-1:0] count_o,
  input logic             no_sfd_o,
  input logic             col_o,
  input logic             start_w,
  input logic             sfd_seen_w
);

  localparam logic [CNT_W-1:0] SHORT_MAX = CNT_W'((1 << SHORT_W) - 1);
  localparam logic [CNT_W-1:0] LONG_MAX  = CNT_W'((1 << LONG_W) - 1);
  localparam logic [CNT_W-1:0] FULL_MAX  = '1;

  // R1
  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (count_o == '0 && !no_sfd_o && !col_o));

  // R2
  p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_w && !byte_stb_i) |=> (count_o == '0 && !no_sfd_o));

  // R3
  p_step_by_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_active_i && !start_w && !sfd_pulse_i) |=>
      (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1));

  // R4
  p_sfd_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_active_i && sfd_pulse_i) |=> (count_o == '0));

  // R4
  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_active_i && !start_w && !sfd_pulse_i && count_o == FULL_MAX) |=> (count_o == FULL_MAX));

  // R5
  p_short_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_active_i && !start_w && !sfd_pulse_i && !sfd_seen_w && !big_size_i && count_o <= SHORT_MAX)
      |=> (count_o <= SHORT_MAX));

  // R6
  p_long_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_active_i && !start_w && !sfd_pulse_i && !sfd_seen_w && big_size_i && count_o <= LONG_MAX)
      |=> (count_o <= LONG_MAX));

  // R7
  p_status_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_active_i |=> !no_sfd_o);

  // R8
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_active_i |=> ($stable(count_o) && $stable(col_o)));

  // R9
  p_col_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_active_i && col_i) |=> col_o);

endmodule

bind pkt_byte_counter pbc_checker #(
  .CNT_W   (CNT_W),
  .SHORT_W (SHORT_W),
  .LONG_W  (LONG_W)
) u_pbc_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pkt_active_i (pkt_active_i),
  .byte_stb_i   (byte_stb_i),
  .sfd_pulse_i  (sfd_pulse_i),
  .big_size_i   (big_size_i),
  .col_i        (col_i),
  .count_o      (count_o),
  .no_sfd_o     (no_sfd_o),
  .col_o        (col_o),
  .start_w      (start_w),
  .sfd_seen_w   (sfd_seen_w)
);

// File: tb/test_pkt_byte_counter.sv
module test_pkt_byte_counter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pkt_active_i = 1'b0;
  logic        byte_stb_i = 1'b0;
  logic        sfd_pulse_i = 1'b0;
  logic        big_size_i = 1'b0;
  logic        col_i = 1'b0;
  logic [15:0] count_o;
  logic        no_sfd_o;
  logic        col_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // reference state
  int m_cnt = 0;
  bit m_nosfd = 0, m_col = 0, m_prev = 0, m_sfd = 0;

  always #4 clk = ~clk;

  pkt_byte_counter i_pkt_byte_counter (
    .clk(clk), .rst_n(rst_n), .pkt_active_i(pkt_active_i), .byte_stb_i(byte_stb_i),
    .sfd_pulse_i(sfd_pulse_i), .big_size_i(big_size_i), .col_i(col_i),
    .count_o(count_o), .no_sfd_o(no_sfd_o), .col_o(col_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int cap_now(bit sfd_seen, bit big);
    if (sfd_seen) return 65535;
    return big ? 2 ** 11 - 1 : 2 ** 7 - 1;
  endfunction

  task automatic check(string tag, int act_c, bit act_n, bit act_l, int exp_c, bit exp_n, bit exp_l);
    checks++;
    if (act_c != exp_c || act_n != exp_n || act_l != exp_l) begin
      errors++;
      $display("FAIL %s: count/no_sfd/col actual %0d/%0d/%0d expected %0d/%0d/%0d",
               tag, act_c, act_n, act_l, exp_c, exp_n, exp_l);
    end
  endtask

  // one cycle: drive at falling edge, advance model, compare at next falling edge
  task automatic step(bit act, bit stb, bit sfd, bit big, bit c);
    string tag;
    bit first, last;
    pkt_active_i = act; byte_stb_i = stb; sfd_pulse_i = sfd; big_size_i = big; col_i = c;
    first = act && !m_prev;
    last  = !act && m_prev;
    tag = "R3";
    if (act) begin
      m_nosfd = 0;
      if (sfd) begin m_cnt = 0; m_sfd = 1; tag = "R4"; end
      else if (first) begin m_cnt = stb ? 1 : 0; m_sfd = 0; tag = "R2"; end
      else if (stb) begin
        if (m_cnt >= cap_now(m_sfd, big))
          tag = m_sfd ? "R4" : (big ? "R6" : "R5");
        else m_cnt = m_cnt + 1;
      end
      m_col = first ? c : (m_col | c);
      if (c) tag = "R9";
    end else if (last) begin
      m_nosfd = !m_sfd; tag = "R7";
    end else tag = "R8";
    m_prev = act;
    @(posedge clk);
    @(negedge clk);
    check(tag, count_o, no_sfd_o, col_o, m_cnt, m_nosfd, m_col);
  endtask

  task automatic send_pkt(int len, int sfd_at, bit big, int pct, int col_at, int gap);
    for (int i = 0; i < len; i++)
      step(1'b1, (i == 0) ? 1'b1 : (($urandom % 100) < pct), i == sfd_at, big, i == col_at);
    for (int g = 0; g < gap; g++)
      step(1'b0, $urandom % 2, $urandom % 2, big, $urandom % 2);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 in reset", count_o, no_sfd_o, col_o, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", count_o, no_sfd_o, col_o, 0, 0, 0);

    // R5: no delimiter, narrow cap
    send_pkt(200, -1, 1'b0, 100, -1, 2);
    check("R5 cap 127", count_o, no_sfd_o, col_o, 127, 1, 0);

    // R6: no delimiter, wide cap
    send_pkt(2100, -1, 1'b1, 100, -1, 2);
    check("R6 cap 2047", count_o, no_sfd_o, col_o, 2047, 1, 0);

    // R4: delimiter at byte 10; its strobe not counted, 39 bytes follow
    send_pkt(50, 10, 1'b0, 100, -1, 2);
    check("R4 post-SFD count", count_o, no_sfd_o, col_o, 39, 0, 0);

    // R9: collision in packet, then a clean packet clears it (R2)
    send_pkt(20, -1, 1'b0, 100, 5, 1);
    check("R9 collision held", count_o, no_sfd_o, col_o, 20, 1, 1);
    send_pkt(8, 3, 1'b0, 100, -1, 1);
    check("R2 col cleared on start", count_o, no_sfd_o, col_o, 4, 0, 0);

    // R8: idle strobes, delimiters and collisions are ignored
    for (int k = 0; k < 6; k++) step(1'b0, 1'b1, k[0], 1'b0, 1'b1);
    check("R8 idle ignored", count_o, no_sfd_o, col_o, 4, 0, 0);

    // R4: full width saturation, delimiter on start cycle
    send_pkt(65600, 0, 1'b0, 100, -1, 2);
    check("R4 cap 65535", count_o, no_sfd_o, col_o, 65535, 0, 0);

    // random packets, back-to-back included
    for (int p = 0; p < 200; p++) begin
      int len, sfd_at, col_at;
      len    = 1 + ($urandom % 250);
      sfd_at = ($urandom % 3 == 0) ? -1 : int'($urandom % len);
      col_at = ($urandom % 4 == 0) ? int'($urandom % len) : -1;
      send_pkt(len, sfd_at, $urandom % 2, 20 + ($urandom % 81), col_at, 1 + ($urandom % 3));
    end
    check("R7 final status", count_o, no_sfd_o, col_o, m_cnt, m_nosfd, m_col);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule